// File: doc/BRIEF.md
# Port Timer with Timestamp Capture

This block is the per-port side of a distributed time base. It keeps a 64-bit timer that follows the low 64 bits of a central source clock. The upper 32 bits count nanoseconds and the lower 32 bits hold a binary fraction. Each clock cycle the timer advances by a 40-bit increment. Software stages a new time, a new increment or a signed nanosecond offset in shadow registers and selects an action in a command field. The action takes effect only when the shared execute strobe arrives, so the source timer and every port timer change in the same cycle.

The block stamps packets from a 40-bit window of the timer, taken at bit offset `TS_LSB`. Every received frame start produces a stamp at an output, one cycle later. A transmitted frame start produces a stamp only when its request line is high. That stamp goes into an indexed store with `DEPTH` entries per port. Software reads an entry as two 32-bit words, one from a low bank and one from a high bank. Writing zero to either word releases the entry. A stamp aimed at an entry that is still held is discarded, and a sticky per-port overflow flag records the loss.

Top module: `port_timestamp_unit`

## Requirements
- R1: After reset, the timer and snapshot are zero and the increment equals `INC_RESET`. All shadow, command and store words read as zero, and no overflow flag is set.
- R2: In a cycle without an execute strobe, the timer advances by the current increment, modulo 2^64.
- R3: An execute strobe with command field (bits 2:0 of the command register at address 0x04) equal to 1 loads the timer with {time shadow high (0x01), time shadow low (0x00)}, replacing that cycle's increment.
- R4: Command 1 is load time. Command 2 sets the increment to {bits 7:0 of the adjust shadow high word (0x03), the adjust shadow low word (0x02)}, and the upper 24 bits of the high word are ignored. The new increment applies from the following cycle.
- R5: Command 3 adds {adjust high, adjust low}, read as a two's-complement 64-bit value, to the timer in addition to that cycle's increment. A negative high word moves time backwards.
- R6: Command 4 copies the timer value from before the strobe edge into a snapshot, which reads as its low word at 0x05 and its high word at 0x06.
- R7: Bits 31:3 of the command register are stored and read back unchanged. Command values 0, 5, 6 and 7 act as no operation. Writing the command register without an execute strobe changes no timer state.
- R8: A received frame start on port p sets `rx_ts_vld[p]` in the next cycle, with `rx_ts` slice p equal to timer[TS_LSB+39:TS_LSB] as it stood at the sampling edge.
- R9: A transmit frame start captures only when its request line is high. The stamp is stored in entry p*DEPTH+idx and marks that entry valid.
- R10: Entry e reads its stamp bits 31:0 at address 0x40+e. At address 0x80+e it reads a word with bit 31 as the valid flag and bits 7:0 as stamp bits 39:32, all other bits zero. Addresses at or beyond TOTAL entries read zero.
- R11: Writing zero to either word of an entry clears that word and the valid flag. Nonzero writes to the store are ignored.
- R12: A capture aimed at a valid entry leaves the entry unchanged and sets `cap_ovf[p]`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_sync | input | 1 | Shared strobe that applies the staged command |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| rx_sof | input | NUM_PORTS | Received frame start, one per port |
| tx_sof | input | NUM_PORTS | Transmitted frame start, one per port |
| tx_req | input | NUM_PORTS | Stamp request that accompanies `tx_sof` |
| tx_idx | input | NUM_PORTS*log2(DEPTH) | Target entry index per port |
| rx_ts | output | NUM_PORTS*40 | Receive stamp per port |
| rx_ts_vld | output | NUM_PORTS | Receive stamp valid |
| cap_ovf | output | NUM_PORTS | Sticky lost-capture flag per port |

## Verification
The hardest situation to reach from the ports is a collision: a transmit capture aimed at an entry that still holds an unread stamp, observed alongside the zero-write release that follows it. The stimulus first fills an entry and proves that an unrequested frame start leaves it alone. It then fires a second requested capture at the same index and checks the sticky flag and the unchanged stamp. After that it tries a nonzero write, then zero writes to each word, and finally a fresh capture into the freed slot. The timer is observed only through snapshot commands, so each staged action is followed by a strobed snapshot.

// File: rtl/ptu_pkg.sv
package ptu_pkg;

    localparam int TS_W   = 40;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        CMD_NOP       = 3'd0,
        CMD_LOAD_TIME = 3'd1,
        CMD_LOAD_INC  = 3'd2,
        CMD_ADJUST    = 3'd3,
        CMD_SNAPSHOT  = 3'd4
    } tmr_cmd_e;

    localparam logic [7:0] A_SHT_LO  = 8'h00;
    localparam logic [7:0] A_SHT_HI  = 8'h01;
    localparam logic [7:0] A_ADJ_LO  = 8'h02;
    localparam logic [7:0] A_ADJ_HI  = 8'h03;
    localparam logic [7:0] A_CMD     = 8'h04;
    localparam logic [7:0] A_SNAP_LO = 8'h05;
    localparam logic [7:0] A_SNAP_HI = 8'h06;
    localparam logic [1:0] BANK_LO   = 2'b01;
    localparam logic [1:0] BANK_HI   = 2'b10;

endpackage

// File: rtl/ptu_clock.sv
module ptu_clock
    import ptu_pkg::*;
#(
    parameter int          TS_LSB    = 24,
    parameter logic [39:0] INC_RESET = 40'h01_0000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        exec_i,
    input  logic [2:0]  cmd_i,
    input  logic [63:0] shtime_i,
    input  logic [63:0] shadj_i,
    output logic [39:0] stamp_o,
    output logic [63:0] snap_o
);

    typedef struct packed {
        logic [63:0]     tmr;
        logic [TS_W-1:0] inc;
        logic [63:0]     snap;
    } clk_st_t;

    clk_st_t q, d;

    always_comb begin
        d     = q;
        d.tmr = q.tmr + {24'b0, q.inc};
        if (exec_i) begin
            case (tmr_cmd_e'(cmd_i))
                CMD_LOAD_TIME: d.tmr  = shtime_i;
                CMD_LOAD_INC:  d.inc  = shadj_i[TS_W-1:0];
                CMD_ADJUST:    d.tmr  = q.tmr + {24'b0, q.inc} + shadj_i;
                CMD_SNAPSHOT:  d.snap = q.tmr;
                default:       ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.tmr  <= '0;
            q.inc  <= INC_RESET;
            q.snap <= '0;
        end else begin
            q <= d;
        end
    end

    assign stamp_o = q.tmr[TS_LSB +: TS_W];
    assign snap_o  = q.snap;

    // R3
    load_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && cmd_i == CMD_LOAD_TIME) |=> q.tmr == $past(shtime_i));

    // R2
    free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> q.tmr == $past(q.tmr) + {24'b0, $past(q.inc)});

    // R6
    snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && cmd_i == CMD_SNAPSHOT) |=> snap_o == $past(q.tmr));

endmodule

// File: rtl/ptu_ts_store.sv
module ptu_ts_store
    import ptu_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int DEPTH     = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NUM_PORTS-1:0]                  cap_i,
    input  logic [NUM_PORTS*$clog2(DEPTH)-1:0]    cap_idx_i,
    input  logic [TS_W-1:0]                       stamp_i,
    input  logic                                  clr_lo_i,
    input  logic                                  clr_hi_i,
    input  logic [$clog2(NUM_PORTS*DEPTH)-1:0]    sel_i,
    output logic [TS_W-1:0]                       rd_ts_o,
    output logic                                  rd_vld_o,
    output logic [NUM_PORTS-1:0]                  ovf_o
);

    localparam int TOTAL = NUM_PORTS * DEPTH;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int SEL_W = $clog2(TOTAL);

    typedef struct packed {
        logic [TOTAL-1:0][TS_W-1:0] ts;
        logic [TOTAL-1:0]           vld;
        logic [NUM_PORTS-1:0]       ovf;
    } store_t;

    store_t q, d;
    logic [NUM_PORTS-1:0][SEL_W-1:0] tgt;

    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            tgt[p] = SEL_W'(p * DEPTH) + SEL_W'(cap_idx_i[p*IDX_W +: IDX_W]);
        end
    end

    always_comb begin
        d = q;
        for (int e = 0; e < TOTAL; e++) begin
            if (clr_lo_i && sel_i == SEL_W'(e)) begin
                d.ts[e][31:0] = '0;
                d.vld[e]      = 1'b0;
            end
            if (clr_hi_i && sel_i == SEL_W'(e)) begin
                d.ts[e][TS_W-1:32] = '0;
                d.vld[e]           = 1'b0;
            end
        end
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (cap_i[p]) begin
                if (q.vld[tgt[p]]) begin
                    d.ovf[p] = 1'b1;
                end else begin
                    d.ts[tgt[p]]  = stamp_i;
                    d.vld[tgt[p]] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_ts_o  = q.ts[sel_i];
    assign rd_vld_o = q.vld[sel_i];
    assign ovf_o    = q.ovf;

    // R12
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (q.ovf & $past(q.ovf)) == $past(q.ovf));

    for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port_chk
        // R12
        drop_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_i[gp] && q.vld[tgt[gp]]) |=> ovf_o[gp]);
        // R9
        capture_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_i[gp] && !q.vld[tgt[gp]]) |=> q.vld[$past(tgt[gp])]);
    end

endmodule

// File: rtl/port_timestamp_unit.sv
module port_timestamp_unit
    import ptu_pkg::*;
#(
    parameter int          NUM_PORTS = 2,
    parameter int          DEPTH     = 4,
    parameter int          TS_LSB    = 24,
    parameter logic [39:0] INC_RESET = 40'h01_0000_0000
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               exec_sync,
    input  logic                               reg_we,
    input  logic [7:0]                         reg_addr,
    input  logic [31:0]                        reg_wdata,
    output logic [31:0]                        reg_rdata,
    input  logic [NUM_PORTS-1:0]               rx_sof,
    input  logic [NUM_PORTS-1:0]               tx_sof,
    input  logic [NUM_PORTS-1:0]               tx_req,
    input  logic [NUM_PORTS*$clog2(DEPTH)-1:0] tx_idx,
    output logic [NUM_PORTS*40-1:0]            rx_ts,
    output logic [NUM_PORTS-1:0]               rx_ts_vld,
    output logic [NUM_PORTS-1:0]               cap_ovf
);

    localparam int TOTAL = NUM_PORTS * DEPTH;
    localparam int SEL_W = $clog2(TOTAL);

    typedef struct packed {
        logic [WORD_W-1:0]               sht_lo;
        logic [WORD_W-1:0]               sht_hi;
        logic [WORD_W-1:0]               adj_lo;
        logic [WORD_W-1:0]               adj_hi;
        logic [WORD_W-1:0]               cmd;
        logic [NUM_PORTS-1:0][TS_W-1:0]  rx_ts;
        logic [NUM_PORTS-1:0]            rx_vld;
    } regs_t;

    regs_t q, d;

    logic [TS_W-1:0]  stamp;
    logic [63:0]      snap;
    logic             hit, clr_lo, clr_hi, rd_vld;
    logic [TS_W-1:0]  rd_ts;
    logic [SEL_W-1:0] sel;

    assign sel    = reg_addr[SEL_W-1:0];
    assign hit    = ({2'b00, reg_addr[5:0]} < 8'(TOTAL));
    assign clr_lo = reg_we && (reg_wdata == '0) && hit && (reg_addr[7:6] == BANK_LO);
    assign clr_hi = reg_we && (reg_wdata == '0) && hit && (reg_addr[7:6] == BANK_HI);

    ptu_clock #(.TS_LSB(TS_LSB), .INC_RESET(INC_RESET)) u_clock (
        .clk      (clk),
        .rst_n    (rst_n),
        .exec_i   (exec_sync),
        .cmd_i    (q.cmd[2:0]),
        .shtime_i ({q.sht_hi, q.sht_lo}),
        .shadj_i  ({q.adj_hi, q.adj_lo}),
        .stamp_o  (stamp),
        .snap_o   (snap)
    );

    ptu_ts_store #(.NUM_PORTS(NUM_PORTS), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_i     (tx_sof & tx_req),
        .cap_idx_i (tx_idx),
        .stamp_i   (stamp),
        .clr_lo_i  (clr_lo),
        .clr_hi_i  (clr_hi),
        .sel_i     (sel),
        .rd_ts_o   (rd_ts),
        .rd_vld_o  (rd_vld),
        .ovf_o     (cap_ovf)
    );

    always_comb begin
        d        = q;
        d.rx_vld = rx_sof;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (rx_sof[p]) d.rx_ts[p] = stamp;
        end
        if (reg_we) begin
            case (reg_addr)
                A_SHT_LO: d.sht_lo = reg_wdata;
                A_SHT_HI: d.sht_hi = reg_wdata;
                A_ADJ_LO: d.adj_lo = reg_wdata;
                A_ADJ_HI: d.adj_hi = reg_wdata;
                A_CMD:    d.cmd    = reg_wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_SHT_LO:  reg_rdata = q.sht_lo;
            A_SHT_HI:  reg_rdata = q.sht_hi;
            A_ADJ_LO:  reg_rdata = q.adj_lo;
            A_ADJ_HI:  reg_rdata = q.adj_hi;
            A_CMD:     reg_rdata = q.cmd;
            A_SNAP_LO: reg_rdata = snap[31:0];
            A_SNAP_HI: reg_rdata = snap[63:32];
            default: begin
                if (hit && reg_addr[7:6] == BANK_LO)
                    reg_rdata = rd_ts[31:0];
                else if (hit && reg_addr[7:6] == BANK_HI)
                    reg_rdata = {rd_vld, 23'b0, rd_ts[TS_W-1:32]};
            end
        endcase
    end

    assign rx_ts     = q.rx_ts;
    assign rx_ts_vld = q.rx_vld;

    // R8
    rx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> rx_ts_vld == $past(rx_sof));

    // R7
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == A_CMD) |=> $stable(q.cmd));

endmodule

// File: tb/port_timestamp_unit_tb.sv
module port_timestamp_unit_tb;

    localparam int NP     = 2;
    localparam int DEPTH  = 4;
    localparam int TS_LSB = 24;
    localparam logic [39:0] INC0 = 40'h01_0000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic exec_sync = 1'b0;
    logic reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NP-1:0] rx_sof = '0, tx_sof = '0, tx_req = '0;
    logic [NP*2-1:0] tx_idx = '0;
    logic [NP*40-1:0] rx_ts;
    logic [NP-1:0] rx_ts_vld, cap_ovf;

    always #2 clk = ~clk;

    port_timestamp_unit #(.NUM_PORTS(NP), .DEPTH(DEPTH), .TS_LSB(TS_LSB), .INC_RESET(INC0)) u_dut (
        .clk(clk), .rst_n(rst_n), .exec_sync(exec_sync), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_sof(rx_sof), .tx_sof(tx_sof),
        .tx_req(tx_req), .tx_idx(tx_idx), .rx_ts(rx_ts), .rx_ts_vld(rx_ts_vld), .cap_ovf(cap_ovf)
    );

    // behavioural reference
    logic [63:0] m_time, m_snap;
    logic [39:0] m_inc;
    logic [31:0] m_shl, m_shh, m_adl, m_adh, m_cmd;
    logic [39:0] m_ts [NP*DEPTH];
    bit          m_vld [NP*DEPTH];
    logic [NP-1:0] m_ovf, m_rxv;
    logic [39:0] m_rx [NP];

    int checks = 0, fails = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    always @(posedge clk) begin
        logic [39:0] st;
        logic [63:0] nt, o_sh, o_adj;
        logic [2:0]  o_cmd;
        bit          ov [NP*DEPTH];
        if (!rst_n) begin
            m_time = '0; m_snap = '0; m_inc = INC0;
            m_shl = '0; m_shh = '0; m_adl = '0; m_adh = '0; m_cmd = '0;
            m_ovf = '0; m_rxv = '0;
            for (int i = 0; i < NP*DEPTH; i++) begin m_ts[i] = '0; m_vld[i] = 0; end
            for (int p = 0; p < NP; p++) m_rx[p] = '0;
        end else begin
            st    = m_time[TS_LSB +: 40];
            o_sh  = {m_shh, m_shl};
            o_adj = {m_adh, m_adl};
            o_cmd = m_cmd[2:0];
            nt    = m_time + {24'b0, m_inc};
            if (exec_sync) begin
                if (o_cmd == 3'd1) nt = o_sh;
                if (o_cmd == 3'd2) m_inc = o_adj[39:0];
                if (o_cmd == 3'd3) nt = nt + o_adj;
                if (o_cmd == 3'd4) m_snap = m_time;
            end
            m_time = nt;
            if (reg_we) begin
                if (reg_addr == 8'h00) m_shl = reg_wdata;
                if (reg_addr == 8'h01) m_shh = reg_wdata;
                if (reg_addr == 8'h02) m_adl = reg_wdata;
                if (reg_addr == 8'h03) m_adh = reg_wdata;
                if (reg_addr == 8'h04) m_cmd = reg_wdata;
            end
            for (int i = 0; i < NP*DEPTH; i++) ov[i] = m_vld[i];
            if (reg_we && reg_wdata == 0 && reg_addr[5:0] < NP*DEPTH) begin
                if (reg_addr[7:6] == 2'b01) begin
                    m_ts[reg_addr[5:0]][31:0] = '0; m_vld[reg_addr[5:0]] = 0;
                end
                if (reg_addr[7:6] == 2'b10) begin
                    m_ts[reg_addr[5:0]][39:32] = '0; m_vld[reg_addr[5:0]] = 0;
                end
            end
            for (int p = 0; p < NP; p++) begin
                int e;
                e = p*DEPTH + int'(tx_idx[p*2 +: 2]);
                if (tx_sof[p] && tx_req[p]) begin
                    if (ov[e]) m_ovf[p] = 1'b1;
                    else begin m_ts[e] = st; m_vld[e] = 1; end
                end
                m_rxv[p] = rx_sof[p];
                if (rx_sof[p]) m_rx[p] = st;
            end
        end
    end

    function automatic logic [31:0] exp_rdata(input logic [7:0] a);
        case (a)
            8'h00: return m_shl;
            8'h01: return m_shh;
            8'h02: return m_adl;
            8'h03: return m_adh;
            8'h04: return m_cmd;
            8'h05: return m_snap[31:0];
            8'h06: return m_snap[63:32];
            default: begin
                if (a[5:0] < NP*DEPTH && a[7:6] == 2'b01) return m_ts[a[5:0]][31:0];
                if (a[5:0] < NP*DEPTH && a[7:6] == 2'b10)
                    return {m_vld[a[5:0]] ? 1'b1 : 1'b0, 23'b0, m_ts[a[5:0]][39:32]};
                return 32'h0;
            end
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, $sformatf("reg_rdata @%h", reg_addr), {32'b0, reg_rdata}, {32'b0, exp_rdata(reg_addr)});
            for (int p = 0; p < NP; p++) begin
                chk("R8", "rx_ts_vld", {63'b0, rx_ts_vld[p]}, {63'b0, m_rxv[p]});
                if (m_rxv[p]) chk("R8", "rx_ts", {24'b0, rx_ts[p*40 +: 40]}, {24'b0, m_rx[p]});
            end
            chk("R12", "cap_ovf", {62'b0, cap_ovf}, {62'b0, m_ovf});
        end
    end

    task automatic summary();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk); #1; reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk); #1; reg_we = 1'b0;
    endtask

    task automatic look(input logic [7:0] a);
        @(negedge clk); #1; reg_addr = a;
        @(negedge clk);
    endtask

    task automatic strobe();
        @(negedge clk); #1; exec_sync = 1'b1;
        @(negedge clk); #1; exec_sync = 1'b0;
    endtask

    task automatic snapshot();
        wr(8'h04, 32'h4); strobe(); look(8'h05); look(8'h06);
    endtask

    task automatic tx(input int p, input logic [1:0] idx, input logic req);
        @(negedge clk); #1; tx_sof[p] = 1'b1; tx_req[p] = req; tx_idx[p*2 +: 2] = idx;
        @(negedge clk); #1; tx_sof = '0; tx_req = '0;
    endtask

    task automatic rx(input logic [NP-1:0] m);
        @(negedge clk); #1; rx_sof = m;
        @(negedge clk); #1; rx_sof = '0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk); #1; rst_n = 1'b1;
        cur_req = "R1";
        look(8'h05); look(8'h06); look(8'h40); look(8'h80); look(8'h04);
        cur_req = "R6";
        snapshot();
        cur_req = "R2";
        repeat (6) @(negedge clk);
        snapshot();
        cur_req = "R3";
        wr(8'h00, 32'h0); wr(8'h01, 32'h1234_5678);
        wr(8'h04, 32'h1); strobe(); snapshot();
        cur_req = "R4";
        wr(8'h02, 32'h8000_0000); wr(8'h03, 32'hABCD_FF02);
        wr(8'h04, 32'h2); strobe(); repeat (3) @(negedge clk); snapshot();
        cur_req = "R5";
        wr(8'h02, 32'h0); wr(8'h03, 32'hFFFF_FF9C);
        wr(8'h04, 32'h3); strobe(); snapshot();
        wr(8'h03, 32'd50); wr(8'h04, 32'h3); strobe(); snapshot();
        cur_req = "R7";
        wr(8'h04, 32'hABCD_0000); look(8'h04); strobe(); snapshot();
        wr(8'h04, 32'hABCD_0001); repeat (4) @(negedge clk);
        wr(8'h04, 32'h5); strobe(); wr(8'h04, 32'h7); strobe();
        look(8'h04); v = reg_rdata;
        wr(8'h04, (v & ~32'h7) | 32'h4); strobe(); look(8'h04); look(8'h06);
        cur_req = "R8";
        rx(2'b01); rx(2'b10); rx(2'b11); repeat (2) @(negedge clk);
        cur_req = "R9";
        tx(0, 2'd1, 1'b0); look(8'h81); look(8'h41);
        tx(0, 2'd1, 1'b1); look(8'h81);
        tx(1, 2'd3, 1'b1); look(8'h87);
        cur_req = "R10";
        look(8'h41); look(8'h47); look(8'h48); look(8'hC1);
        cur_req = "R12";
        tx(0, 2'd1, 1'b1); look(8'h41); look(8'h81); repeat (3) @(negedge clk);
        cur_req = "R11";
        wr(8'h41, 32'hDEAD_BEEF); look(8'h41); look(8'h81);
        wr(8'h41, 32'h0); look(8'h81); look(8'h41);
        wr(8'h87, 32'h0); look(8'h87); look(8'h47);
        tx(0, 2'd1, 1'b1); look(8'h81); look(8'h41);
        repeat (3) @(negedge clk);
        summary();
    end

endmodule